// File: doc/BRIEF.md
# Multi-Input Wake-Up Event Controller

This block watches a set of asynchronous wake-up lines, arranged as groups of eight, and turns selected activity on them into latched events. Each line has its own settings, and each setting lives in a per-group byte register. A mode bit chooses level or edge sensing. A polarity bit chooses high or low for levels and rising or falling for edges. A both-edges bit makes edge sensing respond to either direction. An enable bit admits the line at all.

Detected events set pending bits. Software reads the pending bits and removes them by writing ones to a separate clear register. The pending bits of each group that are also enabled are OR-ed onto an interrupt line. A parameter assigns each group to a line, so several groups can share one line.

Every line first passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one clock earlier. Configuration goes through a simple register port: one write strobe, an address made of a register kind and a group number, and a combinational read path.

Top module: `wkc_top`

## Requirements
- R1: After reset, every configuration and pending register of every group reads as zero and all interrupt outputs are low.
- R2: The register address is `{kind[2:0], group[2:0]}`. The kind codes are 0 for mode, 1 for polarity, 2 for both-edges and 3 for enable. A write with `reg_we` high stores `reg_wdata` at the next clock edge, and `reg_rdata` returns the stored byte combinationally. Bit n of each byte belongs to input `8*group+n`.
- R3: When the mode bit is 1 (level), a polarity bit of 0 detects a high input and 1 detects a low input. Detection repeats on every clock while the level persists.
- R4: When the mode bit is 0 (edge) and the both-edges bit is 0, a polarity bit of 0 detects rising edges only and 1 detects falling edges only.
- R5: When the mode bit is 0 and the both-edges bit is 1, rising and falling edges are both detected, whatever the polarity bit holds.
- R6: An input whose enable bit is 0 never sets its pending bit.
- R7: Kind 4 reads the pending byte, and writes to kind 4 are ignored. A write to kind 5 clears the pending bits where the data has ones and leaves the other bits unchanged. Kind 5 reads as zero.
- R8: When a detection and a clear hit the same bit in the same cycle, the pending bit stays set. An active level therefore survives a clear.
- R9: Interrupt line k is the OR of (pending AND enable) over all groups mapped to k. The default map sends groups 0 and 3 to line 0, group 1 to line 1, group 2 to line 2, and groups 4 to 7 to line 3.
- R10: A change on a wake-up input first shows in the pending register at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_in | input | NGRP*8 | Asynchronous wake-up lines, bit 8*g+n is input n of group g |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3+log2(NGRP) | Register kind in the upper 3 bits, group in the lower bits |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | NIRQ | Merged interrupt lines |

## Verification
The assertions assume that `wake_in` has already passed the synchronizer before it is compared, and that the register address carries a kind in the range 0 to 5 whenever `reg_we` is high. The random stimulus keeps to this: write kinds are drawn from 0 to 5 only, and reads may use any kind, including the unused kinds 6 and 7. The inputs toggle sparsely, by AND-ing several random words together, so that isolated edges and held levels both occur. Directed steps cover each detection style, partial clears, the clear-versus-level collision, and two groups sharing one interrupt line.

// File: rtl/wkc_pkg.sv
package wkc_pkg;

    typedef enum logic [2:0] {
        K_MODE = 3'd0,
        K_POL  = 3'd1,
        K_BOTH = 3'd2,
        K_EN   = 3'd3,
        K_PEND = 3'd4,
        K_CLR  = 3'd5
    } reg_kind_e;

    // Per-bit detection for one group of inputs
    function automatic logic [7:0] detect_byte(
        input logic [7:0] mode, input logic [7:0] pol, input logic [7:0] both,
        input logic [7:0] en,   input logic [7:0] cur, input logic [7:0] prv);
        logic [7:0] rise, fall, lvl, edg;
        rise = cur & ~prv;
        fall = ~cur & prv;
        lvl  = cur ^ pol;
        edg  = (both & (rise | fall)) | (~both & ~pol & rise) | (~both & pol & fall);
        return en & ((mode & lvl) | (~mode & edg));
    endfunction

endpackage

// File: rtl/wkc_sync.sv
module wkc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prv_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prv;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = async_i;
        st_d.s2  = st_q.s1;
        st_d.prv = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o = st_q.s2;
    assign prv_o = st_q.prv;

    // R10: the history stage is exactly one clock behind the current stage
    assert_history_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prv_o == $past(cur_o)));
endmodule

// File: rtl/wkc_group.sv
module wkc_group
    import wkc_pkg::*;
#(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] mode_i,
    input  logic [GW-1:0] pol_i,
    input  logic [GW-1:0] both_i,
    input  logic [GW-1:0] en_i,
    input  logic [GW-1:0] cur_i,
    input  logic [GW-1:0] prv_i,
    input  logic [GW-1:0] clr_i,
    output logic [GW-1:0] pend_o
);
    typedef struct packed {
        logic [GW-1:0] pend;
    } grp_t;

    grp_t st_d, st_q;
    logic [GW-1:0] hit;

    always_comb begin
        hit       = detect_byte(mode_i, pol_i, both_i, en_i, cur_i, prv_i);
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar b = 0; b < GW; b++) begin : g_chk
        assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_i[b] && !pend_o[b]) |=> !pend_o[b]);
        assert_fall_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_o[b]) |-> $past(clr_i[b]));
        assert_level_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i[b] && mode_i[b] && (cur_i[b] != pol_i[b])) |=> pend_o[b]);
        assert_both_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i[b] && !mode_i[b] && both_i[b] && (cur_i[b] != prv_i[b])) |=> pend_o[b]);
    end
endmodule

// File: rtl/wkc_irq_merge.sv
module wkc_irq_merge #(
    parameter int                NGRP    = 8,
    parameter int                NIRQ    = 4,
    parameter logic [NGRP*4-1:0] IRQ_MAP = 32'h3333_0210
) (
    input  logic [NGRP-1:0][7:0] pend_i,
    input  logic [NGRP-1:0][7:0] en_i,
    output logic [NIRQ-1:0]      irq_o
);
    always_comb begin
        irq_o = '0;
        for (int k = 0; k < NIRQ; k++) begin
            for (int g = 0; g < NGRP; g++) begin
                if (IRQ_MAP[g*4 +: 4] == 4'(k))
                    irq_o[k] = irq_o[k] | (|(pend_i[g] & en_i[g]));
            end
        end
    end
endmodule

// File: rtl/wkc_top.sv
module wkc_top
    import wkc_pkg::*;
#(
    parameter int                NGRP    = 8,
    parameter int                NIRQ    = 4,
    parameter logic [NGRP*4-1:0] IRQ_MAP = 32'h3333_0210,
    localparam int               GSW     = $clog2(NGRP),
    localparam int               AW      = 3 + GSW,
    localparam int               NIN     = NGRP * 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIN-1:0]  wake_in,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic [NIRQ-1:0] irq
);
    typedef struct packed {
        logic [NGRP-1:0][7:0] mode;
        logic [NGRP-1:0][7:0] pol;
        logic [NGRP-1:0][7:0] both;
        logic [NGRP-1:0][7:0] en;
    } cfg_t;

    cfg_t                 cfg_d, cfg_q;
    reg_kind_e            kind;
    logic [GSW-1:0]       grp;
    logic [NIN-1:0]       cur, prv;
    logic [NGRP-1:0][7:0] clr, pend;

    assign kind = reg_kind_e'(reg_addr[AW-1 -: 3]);
    assign grp  = reg_addr[GSW-1:0];

    always_comb begin
        cfg_d = cfg_q;
        clr   = '0;
        if (reg_we) begin
            case (kind)
                K_MODE:  cfg_d.mode[grp] = reg_wdata;
                K_POL:   cfg_d.pol[grp]  = reg_wdata;
                K_BOTH:  cfg_d.both[grp] = reg_wdata;
                K_EN:    cfg_d.en[grp]   = reg_wdata;
                K_CLR:   clr[grp]        = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (kind)
            K_MODE:  reg_rdata = cfg_q.mode[grp];
            K_POL:   reg_rdata = cfg_q.pol[grp];
            K_BOTH:  reg_rdata = cfg_q.both[grp];
            K_EN:    reg_rdata = cfg_q.en[grp];
            K_PEND:  reg_rdata = pend[grp];
            default: reg_rdata = '0;
        endcase
    end

    wkc_sync #(.W(NIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wake_in), .cur_o(cur), .prv_o(prv)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        wkc_group #(.GW(8)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .mode_i(cfg_q.mode[g]), .pol_i(cfg_q.pol[g]),
            .both_i(cfg_q.both[g]), .en_i(cfg_q.en[g]),
            .cur_i(cur[g*8 +: 8]), .prv_i(prv[g*8 +: 8]),
            .clr_i(clr[g]), .pend_o(pend[g])
        );

        assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && kind == K_EN && grp == GSW'(g)) |=> (cfg_q.en[g] == $past(reg_wdata)));
    end

    wkc_irq_merge #(.NGRP(NGRP), .NIRQ(NIRQ), .IRQ_MAP(IRQ_MAP)) u_merge (
        .pend_i(pend), .en_i(cfg_q.en), .irq_o(irq)
    );

    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> (|pend));
    assert_clear_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_CLR) |-> (reg_rdata == 8'h00));
endmodule

// File: tb/wkc_top_test.sv
module wkc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wake_in = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [3:0]  irq;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    wkc_top uut (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // ---------------- behavioural model ----------------
    logic [7:0]  m_mode [8];
    logic [7:0]  m_pol  [8];
    logic [7:0]  m_both [8];
    logic [7:0]  m_en   [8];
    logic [7:0]  m_pend [8];
    logic [63:0] m_s1, m_s2, m_pv;

    function automatic logic [7:0] exp_hit(int g);
        logic [7:0] h;
        for (int b = 0; b < 8; b++) begin
            logic c, p;
            c = m_s2[g*8+b];
            p = m_pv[g*8+b];
            if (!m_en[g][b])        h[b] = 1'b0;
            else if (m_mode[g][b])  h[b] = m_pol[g][b] ? !c : c;
            else if (m_both[g][b])  h[b] = (c != p);
            else if (m_pol[g][b])   h[b] = p && !c;
            else                    h[b] = c && !p;
        end
        return h;
    endfunction

    function automatic int line_of(int g);
        if (g == 0 || g == 3) return 0;
        if (g == 1) return 1;
        if (g == 2) return 2;
        return 3;
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        r = '0;
        for (int g = 0; g < 8; g++)
            if ((m_pend[g] & m_en[g]) != 8'h00) r[line_of(g)] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] exp_rd(int k, int g);
        case (k)
            0: return m_mode[g];
            1: return m_pol[g];
            2: return m_both[g];
            3: return m_en[g];
            4: return m_pend[g];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < 8; g++) begin
                m_mode[g] <= '0; m_pol[g] <= '0; m_both[g] <= '0;
                m_en[g] <= '0;   m_pend[g] <= '0;
            end
            m_s1 <= '0; m_s2 <= '0; m_pv <= '0;
        end else begin
            for (int g = 0; g < 8; g++) begin
                logic [7:0] cl;
                cl = (reg_we && reg_addr[5:3] == 3'd5 && reg_addr[2:0] == 3'(g)) ? reg_wdata : 8'h00;
                m_pend[g] <= (m_pend[g] & ~cl) | exp_hit(g);
            end
            if (reg_we) begin
                case (reg_addr[5:3])
                    3'd0: m_mode[reg_addr[2:0]] <= reg_wdata;
                    3'd1: m_pol[reg_addr[2:0]]  <= reg_wdata;
                    3'd2: m_both[reg_addr[2:0]] <= reg_wdata;
                    3'd3: m_en[reg_addr[2:0]]   <= reg_wdata;
                    default: ;
                endcase
            end
            m_s1 <= wake_in; m_s2 <= m_s1; m_pv <= m_s2;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input int k, input int g, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = {3'(k), 3'(g)}; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input int k, input int g, input logic [7:0] exp);
        reg_addr = {3'(k), 3'(g)};
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int k = 0; k < 6; k++)
            for (int g = 0; g < 8; g++)
                rd("R1 reset reg", k, g, 8'h00);
        chk("R1 irq after reset", irq, 4'h0);

        // R2: configuration read/write
        wr(0, 2, 8'hA5); rd("R2 mode readback", 0, 2, 8'hA5);
        wr(1, 5, 8'h3C); rd("R2 polarity readback", 1, 5, 8'h3C);
        wr(2, 7, 8'h81); rd("R2 both readback", 2, 7, 8'h81);
        wr(0, 2, 8'h00); wr(1, 5, 8'h00); wr(2, 7, 8'h00);
        rd("R2 mode restored", 0, 2, 8'h00);

        // R4 / R10: rising edge on input 0
        wr(3, 0, 8'h01);
        wake_in[0] = 1'b1;
        tick(2); rd("R10 not yet pending", 4, 0, 8'h00);
        tick();  rd("R10 R4 rising pending", 4, 0, 8'h01);
        chk("R9 irq line 0 from group 0", irq, 4'b0001);
        wr(5, 0, 8'h01); rd("R7 cleared", 4, 0, 8'h00);
        wake_in[0] = 1'b0;
        tick(4); rd("R4 rising ignores falling", 4, 0, 8'h00);

        // R4: falling edge
        wr(1, 0, 8'h01);
        wake_in[0] = 1'b1;
        tick(4); rd("R4 falling ignores rising", 4, 0, 8'h00);
        wake_in[0] = 1'b0;
        tick(3); rd("R4 falling pending", 4, 0, 8'h01);
        wr(5, 0, 8'h01);

        // R5: both edges, polarity bit still 1
        wr(2, 0, 8'h01);
        wake_in[0] = 1'b1;
        tick(3); rd("R5 both edges rise", 4, 0, 8'h01);
        wr(5, 0, 8'h01); rd("R5 cleared", 4, 0, 8'h00);
        wake_in[0] = 1'b0;
        tick(3); rd("R5 both edges fall", 4, 0, 8'h01);
        wr(5, 0, 8'h01);

        // R6: group 1 disabled
        wake_in[8] = 1'b1;
        tick(4); rd("R6 disabled no pending", 4, 1, 8'h00);
        chk("R6 irq line 1 quiet", irq[1], 1'b0);

        // R3 / R8: level mode on input 9
        wr(0, 1, 8'hFF); wr(1, 1, 8'h00); wr(3, 1, 8'h02);
        wake_in[9] = 1'b1;
        tick(3); rd("R3 level high pending", 4, 1, 8'h02);
        chk("R9 irq line 1", irq[1], 1'b1);
        wr(5, 1, 8'h02); rd("R8 level survives clear", 4, 1, 8'h02);
        wake_in[9] = 1'b0;
        tick(4); wr(5, 1, 8'h02); rd("R3 level gone clears", 4, 1, 8'h00);
        wr(1, 1, 8'h02);
        tick(); rd("R3 level low pending", 4, 1, 8'h02);
        wr(3, 1, 8'h00); wr(5, 1, 8'hFF);
        tick(2); rd("R6 disabled level stays clear", 4, 1, 8'h00);

        // R7: partial clear and ignored pending write
        wr(2, 2, 8'hFF); wr(3, 2, 8'hFF);
        wake_in[23:16] = 8'hFF;
        tick(3); rd("R5 group 2 all set", 4, 2, 8'hFF);
        wr(5, 2, 8'h0F); rd("R7 partial clear", 4, 2, 8'hF0);
        wr(4, 2, 8'h00); rd("R7 pending write ignored", 4, 2, 8'hF0);
        rd("R7 clear reads zero", 5, 2, 8'h00);
        chk("R9 irq line 2", irq, 4'b0100);
        wake_in[23:16] = 8'h00;
        tick(4); wr(5, 2, 8'hFF); rd("R7 full clear", 4, 2, 8'h00);

        // R9: groups 0 and 3 share line 0, group 4 on line 3
        wr(0, 3, 8'h01); wr(1, 3, 8'h01); wr(3, 3, 8'h01);
        tick(); chk("R9 group 3 on shared line 0", irq, 4'b0001);
        wr(0, 4, 8'h80); wr(1, 4, 8'h80); wr(3, 4, 8'h80);
        tick(); chk("R9 group 4 on line 3", irq, 4'b1001);

        // random phase checked against the model
        for (int i = 0; i < 4000; i++) begin
            wake_in = wake_in ^ {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            if ($urandom % 4 == 0) begin
                reg_we = 1'b1;
                reg_addr = {3'($urandom % 6), 3'($urandom)};
                reg_wdata = 8'($urandom);
            end else begin
                reg_we = 1'b0;
                reg_addr = 6'($urandom);
            end
            #1;
            if (!reg_we)
                chk("R2 R3 R4 R5 R7 random read", reg_rdata,
                    exp_rd(int'(reg_addr[5:3]), int'(reg_addr[2:0])));
            chk("R6 R8 R9 random irq", irq, exp_irq());
            @(posedge clk);
            @(negedge clk);
        end
        reg_we = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule